// File: doc/BRIEF.md
# Speculative Unfolded Request Machine

This block hides the delay of a request synchronizer behind useful work. A small Moore machine waits for a request that arrives from another clock domain, takes a data word presented with it, and then steps an accumulator by one per cycle for a fixed number of steps. When the last step is done it raises an acknowledge and holds the result until the request is withdrawn (four-phase handshake).

A conventional design would wait for the request to clear its synchronizer and only then begin counting, so the work takes the synchronizer length plus the step count. Here a short chain of unfolded copies of the next-state function runs all the time on the raw data input, treating it as already valid. Each copy is one step ahead of the one before it. When the synchronized request reaches the live machine, the live state loads the copy that is as many steps deep as the synchronizer is long (or the full step count, if that is shorter), so the request is answered after the larger of the two counts rather than their sum. With no request, the speculative copies are simply never taken.

Top module: `spec_unfold_machine`

## Requirements
- R1: While `rstN` is low, and right after it rises, `ack` is 0 and `result` is 0; a reset in the middle of a transaction returns both to 0.
- R2: A rise of `req` has no effect on `ack` or `result` during the first SYNC_LEN rising clock edges after it is presented, because `req` passes through a SYNC_LEN-stage synchronizer before the live state may use it.
- R3: With `req` presented before rising edge 1 and held, `ack` is 0 after edges 1 through max(STEPS, SYNC_LEN) and is 1 after edge max(STEPS, SYNC_LEN)+1.
- R4: When `ack` rises, `result` equals `d` + STEPS, where `d` is the word held stable from the rise of `req` until `ack`.
- R5: `result` does not change while `ack` is 1, nor after `ack` falls, until a new request is taken.
- R6: After `req` falls with `ack` high, `ack` stays 1 after edges 1 through SYNC_LEN and is 0 after edge SYNC_LEN+1.
- R7: While no request is pending, changes on `d` leave `ack` at 0 and `result` unchanged; the speculative values are discarded.
- R8: The addition in R4 wraps modulo 2^DATA_W.
- R9: Back-to-back handshakes, each starting as soon as the previous `ack` has fallen, each give the result and latency of R3 and R4.
- R10: When STEPS is smaller than SYNC_LEN, the result is still `d` + STEPS and `ack` rises after edge SYNC_LEN+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the machine |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request from the other clock domain, four-phase |
| d | input | DATA_W | Data word, stable from the rise of `req` until `ack` |
| ack | output | 1 | Acknowledge; high while the result is valid |
| result | output | DATA_W | Live accumulator value |

## Verification
The bench builds three instances fed by the same request and data: the default (8-bit, SYNC_LEN 2, STEPS 5), where the live machine still runs three steps after loading the speculative copy; one with STEPS 1, below the synchronizer length, which reaches the R10 path where the live state jumps straight to done; and one with SYNC_LEN 3 and STEPS 3, where the deepest copy is exactly the answer. Each instance is checked edge by edge against its own latency and release timing, with data words chosen so that the sum wraps for some instances and not others.

// File: rtl/usm_pkg.sv
package usm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } usmState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSpec;   // take the speculative copy into the live state
    logic stepLive;   // apply one live next-state step
  } usmStrobe_t;

endpackage

// File: rtl/usm_sync.sv
module usm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/usm_datapath.sv
module usm_datapath
  import usm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SYNC_LEN = 2,
  parameter int STEPS    = 5,
  localparam int TAKE    = (STEPS < SYNC_LEN) ? STEPS : SYNC_LEN,
  localparam int CNT_W   = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] d,
  input  usmStrobe_t        strobe,
  output logic [DATA_W-1:0] acc,
  output logic [CNT_W-1:0]  count,
  output logic              lastStep
);

  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
  localparam logic [CNT_W-1:0]  TAKE_CNT  = CNT_W'(TAKE);
  localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(STEPS - 1);

  // Unfolded copies: spec[k] holds k steps applied to d taken k cycles ago
  logic [DATA_W-1:0] spec [1:TAKE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 1; k <= TAKE; k++) spec[k] <= '0;
    end else begin
      spec[1] <= d + ONE;
      for (int k = 2; k <= TAKE; k++) spec[k] <= spec[k-1] + ONE;
    end
  end

  // Live state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      count <= '0;
    end else if (strobe.loadSpec) begin
      acc   <= spec[TAKE];
      count <= TAKE_CNT;
    end else if (strobe.stepLive) begin
      acc   <= acc + ONE;
      count <= count + CNT_W'(1);
    end
  end

  assign lastStep = (count == LAST_CNT);

endmodule

// File: rtl/usm_ctrl.sv
module usm_ctrl
  import usm_pkg::*;
#(
  parameter int SYNC_LEN = 2,
  parameter int STEPS    = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncReq,
  input  logic       lastStep,
  output usmStrobe_t strobe,
  output logic       ack
);

  usmState_e state, nextState, loadTarget;

  // Variant: if the speculative copy already covers every step, skip RUN
  generate
    if (STEPS <= SYNC_LEN) begin : g_direct
      assign loadTarget = ST_DONE;
    end else begin : g_tail
      assign loadTarget = ST_RUN;
    end
  endgenerate

  always_comb begin
    nextState       = state;
    strobe.loadSpec = 1'b0;
    strobe.stepLive = 1'b0;
    unique case (state)
      ST_IDLE: if (syncReq) begin
        strobe.loadSpec = 1'b1;
        nextState       = loadTarget;
      end
      ST_RUN: begin
        strobe.stepLive = 1'b1;
        if (lastStep) nextState = ST_DONE;
      end
      ST_DONE: if (!syncReq) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign ack = (state == ST_DONE);

endmodule

// File: rtl/spec_unfold_machine.sv
module spec_unfold_machine
  import usm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SYNC_LEN = 2,
  parameter int STEPS    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [DATA_W-1:0] d,
  output logic              ack,
  output logic [DATA_W-1:0] result
);

  localparam int CNT_W = $clog2(STEPS + 1);

  logic             syncReq;
  logic             lastStep;
  logic [CNT_W-1:0] liveCount;
  usmStrobe_t       strobe;

  usm_sync #(.STAGES(SYNC_LEN)) syncU (
    .clk(clk), .rstN(rstN), .asyncIn(req), .syncOut(syncReq)
  );

  usm_ctrl #(.SYNC_LEN(SYNC_LEN), .STEPS(STEPS)) ctrlU (
    .clk(clk), .rstN(rstN), .syncReq(syncReq), .lastStep(lastStep),
    .strobe(strobe), .ack(ack)
  );

  usm_datapath #(.DATA_W(DATA_W), .SYNC_LEN(SYNC_LEN), .STEPS(STEPS)) dpU (
    .clk(clk), .rstN(rstN), .d(d), .strobe(strobe),
    .acc(result), .count(liveCount), .lastStep(lastStep)
  );

endmodule

// File: rtl/usm_checker.sv
module usm_checker #(
  parameter int DATA_W = 8,
  parameter int STEPS  = 5,
  localparam int CNT_W = $clog2(STEPS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic              ack,
  input logic [DATA_W-1:0] result,
  input logic [CNT_W-1:0]  liveCount
);

  // R3: acknowledge only rises for a request still held
  p_ack_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> req);

  // R3: live step count never passes the configured step count
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    liveCount <= CNT_W'(STEPS));

  // R6: acknowledge holds while the request is held
  p_ack_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ack && req) |=> ack);

  // R6: acknowledge only drops once the request is gone
  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ack) |-> !req);

  // R5: result frozen while acknowledged and in the cycle after
  p_result_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> $stable(result));

endmodule

bind spec_unfold_machine usm_checker #(.DATA_W(DATA_W), .STEPS(STEPS)) chkU (
  .clk(clk), .rstN(rstN), .req(req), .ack(ack), .result(result),
  .liveCount(liveCount)
);

// File: tb/spec_unfold_machine_test.sv
module spec_unfold_machine_test;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;
  // per instance: steps, sync length, ack latency, release latency
  localparam int STEPSV [NI] = '{5, 1, 3};
  localparam int SYNCV  [NI] = '{2, 2, 3};
  localparam int LAT    [NI] = '{6, 3, 4};
  localparam int DROP   [NI] = '{3, 3, 4};

  // stimulus d and expected result of the default instance (d + 5)
  localparam logic [15:0] VEC [6] = '{
    {8'h00, 8'h05}, {8'h10, 8'h15}, {8'hFA, 8'hFF},
    {8'hFB, 8'h00}, {8'hFF, 8'h04}, {8'h7E, 8'h83}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       req = 1'b0;
  logic [7:0] d = '0;
  logic       ackV [NI];
  logic [7:0] resV [NI];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_unfold_machine #(.DATA_W(8), .SYNC_LEN(2), .STEPS(5)) uut (
    .clk(clk), .rstN(rstN), .req(req), .d(d), .ack(ackV[0]), .result(resV[0]));
  spec_unfold_machine #(.DATA_W(8), .SYNC_LEN(2), .STEPS(1)) uutShort (
    .clk(clk), .rstN(rstN), .req(req), .d(d), .ack(ackV[1]), .result(resV[1]));
  spec_unfold_machine #(.DATA_W(8), .SYNC_LEN(3), .STEPS(3)) uutDeep (
    .clk(clk), .rstN(rstN), .req(req), .d(d), .ack(ackV[2]), .result(resV[2]));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic handshake(input logic [7:0] dVal, input logic [7:0] expMain);
    logic [7:0] prev [NI];
    logic [7:0] expR [NI];
    for (int i = 0; i < NI; i++) begin
      prev[i] = resV[i];
      expR[i] = dVal + 8'(STEPSV[i]);
    end
    check(expR[0] == expMain, "R4 table", expR[0], expMain);
    req = 1'b1;
    d   = dVal;
    for (int k = 1; k <= 7; k++) begin
      tick();
      for (int i = 0; i < NI; i++) begin
        if (k <= SYNCV[i]) begin
          check(ackV[i] == 1'b0, "R2 ack", ackV[i], 0);
          check(resV[i] == prev[i], "R2 result", resV[i], prev[i]);
        end else if (k < LAT[i]) begin
          check(ackV[i] == 1'b0, "R3 early", ackV[i], 0);
        end else begin
          check(ackV[i] == 1'b1, (i == 1) ? "R10 ack" : "R3 ack", ackV[i], 1);
          check(resV[i] == expR[i],
                (i == 1) ? "R10 result" : ((dVal + 9'(STEPSV[i])) > 9'd255 ? "R8 wrap" : "R4 result"),
                resV[i], expR[i]);
        end
      end
    end
    req = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      tick();
      for (int i = 0; i < NI; i++) begin
        check(ackV[i] == (k < DROP[i]), "R6 release", ackV[i], int'(k < DROP[i]));
        check(resV[i] == expR[i], "R5 hold", resV[i], expR[i]);
      end
    end
  endtask

  initial begin
    logic [7:0] held [NI];
    #2;
    // R1: during reset
    for (int i = 0; i < NI; i++) begin
      check(ackV[i] == 1'b0, "R1 ack in reset", ackV[i], 0);
      check(resV[i] == 8'h00, "R1 result in reset", resV[i], 0);
    end
    tick();
    rstN = 1'b1;
    tick();
    for (int i = 0; i < NI; i++) begin
      check(ackV[i] == 1'b0, "R1 ack after reset", ackV[i], 0);
      check(resV[i] == 8'h00, "R1 result after reset", resV[i], 0);
    end

    // Table walk, back to back (R2 R3 R4 R5 R6 R8 R9 R10)
    for (int v = 0; v < 6; v++) handshake(VEC[v][15:8], VEC[v][7:0]);

    // R7: data moving while idle is ignored
    for (int i = 0; i < NI; i++) held[i] = resV[i];
    for (int k = 0; k < 8; k++) begin
      d = 8'(8'h31 * k + 3);
      tick();
      for (int i = 0; i < NI; i++) begin
        check(ackV[i] == 1'b0, "R7 ack idle", ackV[i], 0);
        check(resV[i] == held[i], "R7 result idle", resV[i], held[i]);
      end
    end

    // R9: one more transaction right after idle data noise
    handshake(8'h42, 8'h47);

    // R1: reset in the middle of a transaction
    req = 1'b1;
    d   = 8'h20;
    tick(); tick(); tick(); tick();
    rstN = 1'b0;
    #1;
    for (int i = 0; i < NI; i++) begin
      check(ackV[i] == 1'b0, "R1 mid-run ack", ackV[i], 0);
      check(resV[i] == 8'h00, "R1 mid-run result", resV[i], 0);
    end
    req = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick(); tick(); tick(); tick();
    for (int i = 0; i < NI; i++) begin
      check(ackV[i] == 1'b0, "R1 after mid-run reset", ackV[i], 0);
      check(resV[i] == 8'h00, "R1 result after mid-run reset", resV[i], 0);
    end

    // R9: clean transaction after the reset
    handshake(8'hC3, 8'hC8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule